// File: doc/BRIEF.md
# Split Instruction/Data Set-Associative TLB Lookup

This block is a software-loaded translation lookaside buffer. It has an instruction half and a data half, and each half is a small set-associative array. A lookup presents an effective address, a compare tag that the caller has already derived, a one-bit access key, a no-execute flag and an access type (load, store or fetch).

Within one cycle the block searches every way of the indexed set on the selected half. It returns a result code, the real page number, the storage attributes, the protection triple and the entry's current referenced/changed flags. On the clock edge that ends a hit cycle, it writes the updated referenced and changed flags back into the hit entry. Software loads entries through a single write port. Page-table walks, exception generation and tag derivation belong to the surrounding logic.

Entry word 0 is laid out as follows:

- bit 31 is the valid bit.
- bits 30:7 and 5:0 together form the 30-bit tag.
- bit 6 is the hash-select bit.

Entry word 1 is laid out as follows:

- bits 31:12 hold the real page number.
- bit 8 is the referenced flag.
- bit 7 is the changed flag.
- bits 6:3 hold the storage attributes.
- bits 1:0 hold the page-protection code (PP).

Lookup and software write ports carry no handshake. There is no state machine: the only sequential behaviour is the flag write-back and the software write.

Top module: `tlb_split_lookup`

## Requirements
- R1: After reset every entry is invalid, so any lookup returns code 1 (miss). While `lk_valid` is low, the outputs show code 1, `lk_hit` 0 and `lk_prot` 0.
- R2: The set is the effective page number (`lk_ea[31:12]`) modulo the set count. Entry number = way × sets + set, plus ways × sets for the instruction half. Access type 2 (fetch) searches only the instruction half; types 0 (load) and 1 (store) search only the data half. `wr_fetch_side` selects the half to write.
- R3: An entry matches only if all four conditions hold: it is valid, its hash-select bit is 0, its stored page number equals `lk_ea[31:12]`, and its tag equals `lk_tag`.
- R4: The protection triple `lk_prot` is {read, write, execute}, with read in bit 2. With key 0, PP 0, 1 and 2 give read and write, and PP 3 gives read only. With key 1, PP 0 gives nothing, PP 1 and 3 give read only, and PP 2 gives read and write. Execute equals read unless `lk_nx` is set, in which case execute is 0.
- R5: A load needs read, a store needs write and a fetch needs execute. A matching entry that allows the access ends the search with code 0 and `lk_hit` 1, and returns its real page number and attributes.
- R6: A match that denies the access gives code 2 and `lk_hit` 1, and the search continues in the following ways.
- R7: Once one match has been recorded, a later match whose real page number, attributes or PP differ is an inconsistency. The result is then code 3 with `lk_hit` 0, unless an earlier way already granted the access, in which case the result is code 0.
- R8: Each code 0 or code 2 result sets the referenced flag of the selected entry at the closing clock edge. `lk_rc` = {referenced, changed} shows the flags as they were before that update.
- R9: The changed flag is set only by a store that returned code 0. In every other case where the changed flag is still clear, write is removed from the returned `lk_prot`.
- R10: When a software write and a hit write-back target the same entry in the same cycle, the software write wins completely.
- R11: Code 1 and code 3 results leave all entries unchanged and return zero page number, attributes, protection and flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears valid bits |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_ea | input | ADDR_W | Effective address |
| lk_tag | input | 30 | Compare tag |
| lk_key | input | 1 | Access key |
| lk_nx | input | 1 | No-execute segment flag |
| lk_acc | input | 2 | 0 load, 1 store, 2 fetch |
| lk_hit | output | 1 | Code 0 or code 2 result |
| lk_code | output | 2 | 0 granted, 1 miss, 2 denied, 3 inconsistent |
| lk_rpn | output | 32-PAGE_BITS | Real page number |
| lk_wimg | output | 4 | Storage attributes |
| lk_prot | output | 3 | {read, write, execute} |
| lk_rc | output | 2 | {referenced, changed} before update |
| wr_en | input | 1 | Software entry write |
| wr_fetch_side | input | 1 | 1 selects the instruction half |
| wr_way | input | log2(WAYS) | Way to write |
| wr_set | input | log2(SETS) | Set to write |
| wr_epn | input | ADDR_W-PAGE_BITS | Stored page number |
| wr_w0 | input | 32 | Entry word 0 |
| wr_w1 | input | 32 | Entry word 1 |

## Verification
Two functions can meet in the same cycle: the flag write-back of a lookup hit and a software write to the entry that lookup selected. The bench provokes this by driving a hitting load and a software write to the same half, way and set in one cycle.

It judges the outcome with the following lookup. That lookup must return the software-written page number, with both flags clear. The write-back to a different entry, in contrast, must show up as a set referenced flag.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        RES_GRANT    = 2'd0,
        RES_MISS     = 2'd1,
        RES_DENY     = 2'd2,
        RES_CONFLICT = 2'd3
    } res_e;

    localparam int unsigned W1_REF_BIT = 8;
    localparam int unsigned W1_CHG_BIT = 7;

    // {read, write, execute} from key, protection code and no-execute flag
    function automatic logic [2:0] pp_to_prot(input logic key, input logic [1:0] pp,
                                              input logic nx);
        logic rd, wt;
        if (!key) begin
            rd = 1'b1;
            wt = (pp != 2'd3);
        end else begin
            rd = (pp != 2'd0);
            wt = (pp == 2'd2);
        end
        return {rd, wt, rd & ~nx};
    endfunction

    function automatic logic prot_allows(input acc_e acc, input logic [2:0] prot);
        logic ok;
        unique case (acc)
            ACC_LOAD:  ok = prot[2];
            ACC_STORE: ok = prot[1];
            ACC_FETCH: ok = prot[0];
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/tlb_array.sv
module tlb_array #(
    parameter int WAYS  = 2,
    parameter int SETS  = 32,
    parameter int EPN_W = 20,
    parameter int NUM_W = 7
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [NUM_W-1:0]               wr_num,
    input  logic                           wr_vld,
    input  logic [EPN_W-1:0]               wr_epn,
    input  logic [29:0]                    wr_tag,
    input  logic                           wr_hsel,
    input  logic [31:0]                    wr_w1,
    input  logic                           upd_en,
    input  logic [NUM_W-1:0]               upd_num,
    input  logic [31:0]                    upd_w1,
    input  logic [WAYS-1:0][NUM_W-1:0]     rd_num,
    output logic [WAYS-1:0]                rd_vld,
    output logic [WAYS-1:0][EPN_W-1:0]     rd_epn,
    output logic [WAYS-1:0][29:0]          rd_tag,
    output logic [WAYS-1:0]                rd_hsel,
    output logic [WAYS-1:0][31:0]          rd_w1
);
    localparam int TOTAL = 2 * WAYS * SETS;

    logic [TOTAL-1:0] vld_q;
    logic [EPN_W-1:0] epn_q  [TOTAL];
    logic [29:0]      tag_q  [TOTAL];
    logic             hsel_q [TOTAL];
    logic [31:0]      w1_q   [TOTAL];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_num] <= wr_vld;
        end
    end

    // Software write is placed last so that it overrides a same-entry flag update
    always_ff @(posedge clk) begin
        if (upd_en) begin
            w1_q[upd_num] <= upd_w1;
        end
        if (wr_en) begin
            epn_q[wr_num]  <= wr_epn;
            tag_q[wr_num]  <= wr_tag;
            hsel_q[wr_num] <= wr_hsel;
            w1_q[wr_num]   <= wr_w1;
        end
    end

    for (genvar g = 0; g < WAYS; g++) begin : g_rd
        assign rd_vld[g]  = vld_q[rd_num[g]];
        assign rd_epn[g]  = epn_q[rd_num[g]];
        assign rd_tag[g]  = tag_q[rd_num[g]];
        assign rd_hsel[g] = hsel_q[rd_num[g]];
        assign rd_w1[g]   = w1_q[rd_num[g]];
    end

endmodule

// File: rtl/tlb_way_check.sv
module tlb_way_check
    import tlb_pkg::*;
#(
    parameter int EPN_W = 20
) (
    input  logic             ent_vld,
    input  logic [EPN_W-1:0] ent_epn,
    input  logic [29:0]      ent_tag,
    input  logic             ent_hsel,
    input  logic [1:0]       ent_pp,
    input  logic [EPN_W-1:0] la_epn,
    input  logic [29:0]      la_tag,
    input  logic             la_key,
    input  logic             la_nx,
    input  acc_e             la_acc,
    output logic             way_match,
    output logic             way_grant,
    output logic [2:0]       way_prot
);
    always_comb begin
        way_match = ent_vld && !ent_hsel && (ent_epn == la_epn) && (ent_tag == la_tag);
        way_prot  = pp_to_prot(la_key, ent_pp, la_nx);
        way_grant = way_match && prot_allows(la_acc, way_prot);
    end
endmodule

// File: rtl/tlb_split_lookup.sv
module tlb_split_lookup
    import tlb_pkg::*;
#(
    parameter int WAYS      = 2,
    parameter int SETS      = 32,
    parameter int PAGE_BITS = 12,
    parameter int ADDR_W    = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          lk_valid,
    input  logic [ADDR_W-1:0]             lk_ea,
    input  logic [29:0]                   lk_tag,
    input  logic                          lk_key,
    input  logic                          lk_nx,
    input  logic [1:0]                    lk_acc,
    output logic                          lk_hit,
    output logic [1:0]                    lk_code,
    output logic [31-PAGE_BITS:0]         lk_rpn,
    output logic [3:0]                    lk_wimg,
    output logic [2:0]                    lk_prot,
    output logic [1:0]                    lk_rc,
    input  logic                          wr_en,
    input  logic                          wr_fetch_side,
    input  logic [$clog2(WAYS)-1:0]       wr_way,
    input  logic [$clog2(SETS)-1:0]       wr_set,
    input  logic [ADDR_W-PAGE_BITS-1:0]   wr_epn,
    input  logic [31:0]                   wr_w0,
    input  logic [31:0]                   wr_w1
);
    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int EPN_W = ADDR_W - PAGE_BITS;
    localparam int HALF  = WAYS * SETS;
    localparam int NUM_W = $clog2(2 * HALF);
    localparam logic [31:0] CONS_MASK =
        {{(32-PAGE_BITS){1'b1}}, {(PAGE_BITS-7){1'b0}}, 7'b1111011};

    acc_e             la_acc;
    logic             la_fetch;
    logic [IDX_W-1:0] la_set;
    logic [EPN_W-1:0] la_epn;

    assign la_acc   = acc_e'(lk_acc);
    assign la_fetch = (la_acc == ACC_FETCH);
    assign la_set   = lk_ea[PAGE_BITS +: IDX_W];
    assign la_epn   = lk_ea[ADDR_W-1:PAGE_BITS];

    logic [WAYS-1:0][NUM_W-1:0] rd_num;
    logic [WAYS-1:0]            rd_vld;
    logic [WAYS-1:0][EPN_W-1:0] rd_epn;
    logic [WAYS-1:0][29:0]      rd_tag;
    logic [WAYS-1:0]            rd_hsel;
    logic [WAYS-1:0][31:0]      rd_w1;
    logic [WAYS-1:0]            chk_match;
    logic [WAYS-1:0]            chk_grant;
    logic [WAYS-1:0][2:0]       chk_prot;

    logic [NUM_W-1:0] wr_num;
    logic             upd_en;
    logic [NUM_W-1:0] upd_num;
    logic [31:0]      upd_w1;

    assign wr_num = NUM_W'(int'(wr_fetch_side) * HALF + int'(wr_way) * SETS + int'(wr_set));

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        assign rd_num[g] = NUM_W'(int'(la_fetch) * HALF + g * SETS + int'(la_set));

        tlb_way_check #(.EPN_W(EPN_W)) u_check (
            .ent_vld  (rd_vld[g]),
            .ent_epn  (rd_epn[g]),
            .ent_tag  (rd_tag[g]),
            .ent_hsel (rd_hsel[g]),
            .ent_pp   (rd_w1[g][1:0]),
            .la_epn   (la_epn),
            .la_tag   (lk_tag),
            .la_key   (lk_key),
            .la_nx    (lk_nx),
            .la_acc   (la_acc),
            .way_match(chk_match[g]),
            .way_grant(chk_grant[g]),
            .way_prot (chk_prot[g])
        );
    end

    tlb_array #(.WAYS(WAYS), .SETS(SETS), .EPN_W(EPN_W), .NUM_W(NUM_W)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_num (wr_num),
        .wr_vld (wr_w0[31]),
        .wr_epn (wr_epn),
        .wr_tag ({wr_w0[30:7], wr_w0[5:0]}),
        .wr_hsel(wr_w0[6]),
        .wr_w1  (wr_w1),
        .upd_en (upd_en),
        .upd_num(upd_num),
        .upd_w1 (upd_w1),
        .rd_num (rd_num),
        .rd_vld (rd_vld),
        .rd_epn (rd_epn),
        .rd_tag (rd_tag),
        .rd_hsel(rd_hsel),
        .rd_w1  (rd_w1)
    );

    // Way search: first grant stops, a disagreeing later match is flagged
    logic             s_found, s_done, s_conflict;
    logic [WAY_W-1:0] s_best;
    logic [31:0]      s_first;

    always_comb begin
        s_found    = 1'b0;
        s_done     = 1'b0;
        s_conflict = 1'b0;
        s_best     = '0;
        s_first    = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!s_done && chk_match[w]) begin
                if (s_found && (((rd_w1[w] ^ s_first) & CONS_MASK) != '0)) begin
                    s_conflict = 1'b1;
                end else begin
                    s_found = 1'b1;
                    s_first = rd_w1[w];
                    s_best  = WAY_W'(w);
                    if (chk_grant[w]) s_done = 1'b1;
                end
            end
        end
    end

    res_e        res;
    logic        sel_hit;
    logic        store_ok;
    logic [31:0] sel_w1;

    always_comb begin
        if (!lk_valid)       res = RES_MISS;
        else if (s_done)     res = RES_GRANT;
        else if (s_conflict) res = RES_CONFLICT;
        else if (s_found)    res = RES_DENY;
        else                 res = RES_MISS;
        sel_hit  = (res == RES_GRANT) || (res == RES_DENY);
        store_ok = (res == RES_GRANT) && (la_acc == ACC_STORE);
        sel_w1   = rd_w1[s_best];
    end

    always_comb begin
        lk_code = res;
        lk_hit  = sel_hit;
        lk_rpn  = '0;
        lk_wimg = '0;
        lk_prot = '0;
        lk_rc   = '0;
        if (sel_hit) begin
            lk_rpn  = sel_w1[31:PAGE_BITS];
            lk_wimg = sel_w1[6:3];
            lk_rc   = {sel_w1[W1_REF_BIT], sel_w1[W1_CHG_BIT]};
            lk_prot = chk_prot[s_best];
            if (!sel_w1[W1_CHG_BIT] && !store_ok) lk_prot[1] = 1'b0;
        end
    end

    always_comb begin
        upd_en  = sel_hit;
        upd_num = rd_num[s_best];
        upd_w1  = sel_w1;
        upd_w1[W1_REF_BIT] = 1'b1;
        if (store_ok) upd_w1[W1_CHG_BIT] = 1'b1;
    end

endmodule

// File: rtl/tlb_split_lookup_chk.sv
module tlb_split_lookup_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       lk_valid,
    input logic [1:0] lk_acc,
    input logic       lk_nx,
    input logic       lk_hit,
    input logic [1:0] lk_code,
    input logic [2:0] lk_prot,
    input logic [1:0] lk_rc
);
    assert_idle_miss_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (lk_code == 2'd1 && !lk_hit && lk_prot == 3'd0));

    assert_nx_no_exec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && lk_nx) |-> !lk_prot[0]);

    assert_grant_allows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_code == 2'd0) |->
            ((lk_acc == 2'd0 && lk_prot[2]) || (lk_acc == 2'd1 && lk_prot[1]) ||
             (lk_acc == 2'd2 && lk_prot[0])));

    assert_deny_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_code == 2'd2) |->
            (lk_hit && !((lk_acc == 2'd0 && lk_prot[2]) || (lk_acc == 2'd1 && lk_prot[1]) ||
                         (lk_acc == 2'd2 && lk_prot[0]))));

    assert_first_write_faults_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && lk_acc != 2'd1 && !lk_rc[0]) |-> !lk_prot[1]);
endmodule

bind tlb_split_lookup tlb_split_lookup_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .lk_valid(lk_valid),
    .lk_acc  (lk_acc),
    .lk_nx   (lk_nx),
    .lk_hit  (lk_hit),
    .lk_code (lk_code),
    .lk_prot (lk_prot),
    .lk_rc   (lk_rc)
);

// File: tb/tlb_split_lookup_tb_top.sv
module tlb_split_lookup_tb_top;
    localparam int WAYS = 2;
    localparam int SETS = 32;
    localparam int TOTAL = 2 * WAYS * SETS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_ea = '0;
    logic [29:0] lk_tag = '0;
    logic        lk_key = 1'b0;
    logic        lk_nx = 1'b0;
    logic [1:0]  lk_acc = '0;
    logic        lk_hit;
    logic [1:0]  lk_code;
    logic [19:0] lk_rpn;
    logic [3:0]  lk_wimg;
    logic [2:0]  lk_prot;
    logic [1:0]  lk_rc;
    logic        wr_en = 1'b0;
    logic        wr_fetch_side = 1'b0;
    logic [0:0]  wr_way = '0;
    logic [4:0]  wr_set = '0;
    logic [19:0] wr_epn = '0;
    logic [31:0] wr_w0 = '0;
    logic [31:0] wr_w1 = '0;

    always #5 clk = ~clk;

    tlb_split_lookup dut_i (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ea(lk_ea), .lk_tag(lk_tag),
        .lk_key(lk_key), .lk_nx(lk_nx), .lk_acc(lk_acc), .lk_hit(lk_hit), .lk_code(lk_code),
        .lk_rpn(lk_rpn), .lk_wimg(lk_wimg), .lk_prot(lk_prot), .lk_rc(lk_rc),
        .wr_en(wr_en), .wr_fetch_side(wr_fetch_side), .wr_way(wr_way), .wr_set(wr_set),
        .wr_epn(wr_epn), .wr_w0(wr_w0), .wr_w1(wr_w1)
    );

    typedef struct {
        logic [1:0]  code;
        logic [19:0] rpn;
        logic [3:0]  wimg;
        logic [2:0]  prot;
        logic [1:0]  rc;
        string       req;
    } exp_t;

    exp_t scb_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   ended  = 1'b0;

    // Reference state, kept from the requirements
    bit          m_vld [TOTAL];
    logic [19:0] m_epn [TOTAL];
    logic [29:0] m_tag [TOTAL];
    logic        m_hs  [TOTAL];
    logic [31:0] m_w1  [TOTAL];

    function automatic logic [31:0] mk_w0(input logic [29:0] tag, input logic hs);
        return {1'b1, tag[29:6], hs, tag[5:0]};
    endfunction

    function automatic logic [31:0] mk_w1(input logic [19:0] rpn, input logic r,
                                          input logic c, input logic [3:0] wimg,
                                          input logic [1:0] pp);
        return {rpn, 3'b000, r, c, wimg, 1'b0, pp};
    endfunction

    function automatic logic [2:0] ref_prot(input logic key, input logic [1:0] pp,
                                            input logic nx);
        logic [1:0] rw;
        case ({key, pp})
            3'b000, 3'b001, 3'b010: rw = 2'b11;
            3'b011:                 rw = 2'b10;
            3'b100:                 rw = 2'b00;
            3'b110:                 rw = 2'b11;
            default:                rw = 2'b10;
        endcase
        return {rw, rw[1] & ~nx};
    endfunction

    function automatic exp_t ref_lookup(input logic [31:0] ea, input logic [29:0] tag,
                                        input logic key, input logic nx,
                                        input logic [1:0] acc, output bit upd,
                                        output int unum, output logic [31:0] unew);
        exp_t e;
        int set, base, best, n;
        bit found, granted, confl, ok;
        logic [31:0] first;
        logic [2:0] p;
        set = int'(ea[31:12]) % SETS;
        base = (acc == 2'd2) ? WAYS * SETS : 0;
        found = 0; granted = 0; confl = 0; best = 0; first = '0;
        for (int w = 0; w < WAYS; w++) begin
            n = base + w * SETS + set;
            if (!granted && m_vld[n] && !m_hs[n] && m_epn[n] == ea[31:12] && m_tag[n] == tag) begin
                if (found && ((m_w1[n] ^ first) & 32'hFFFF_F07B) != 0) begin
                    confl = 1;
                end else begin
                    found = 1; first = m_w1[n]; best = n;
                    p = ref_prot(key, m_w1[n][1:0], nx);
                    ok = (acc == 2'd0) ? p[2] : (acc == 2'd1) ? p[1] : p[0];
                    if (ok) granted = 1;
                end
            end
        end
        e.code = granted ? 2'd0 : confl ? 2'd3 : found ? 2'd2 : 2'd1;
        e.rpn = '0; e.wimg = '0; e.prot = '0; e.rc = '0; e.req = "";
        upd = (e.code == 2'd0 || e.code == 2'd2);
        unum = best;
        unew = m_w1[best] | 32'h100 | ((granted && acc == 2'd1) ? 32'h80 : 32'h0);
        if (upd) begin
            e.rpn  = m_w1[best][31:12];
            e.wimg = m_w1[best][6:3];
            e.rc   = {m_w1[best][8], m_w1[best][7]};
            e.prot = ref_prot(key, m_w1[best][1:0], nx);
            if (!m_w1[best][7] && !(granted && acc == 2'd1)) e.prot[1] = 1'b0;
        end
        return e;
    endfunction

    // Driver: one operation per cycle, lookup and/or software write
    task automatic op(input string req, input bit chk, input bit lv, input logic [31:0] ea,
                      input logic [29:0] tag, input logic key, input logic nx,
                      input logic [1:0] acc, input bit we, input logic side,
                      input logic way, input logic [4:0] set, input logic [19:0] epn,
                      input logic [31:0] w0, input logic [31:0] w1);
        exp_t e;
        bit upd;
        int unum, wn;
        logic [31:0] unew;
        @(negedge clk);
        lk_valid = lv; lk_ea = ea; lk_tag = tag; lk_key = key; lk_nx = nx; lk_acc = acc;
        wr_en = we; wr_fetch_side = side; wr_way = way; wr_set = set; wr_epn = epn;
        wr_w0 = w0; wr_w1 = w1;
        if (lv) begin
            e = ref_lookup(ea, tag, key, nx, acc, upd, unum, unew);
            if (upd) m_w1[unum] = unew;
        end else begin
            e = '{code: 2'd1, rpn: '0, wimg: '0, prot: '0, rc: '0, req: ""};
        end
        e.req = req;
        if (chk) scb_q.push_back(e);
        if (we) begin
            wn = int'(side) * WAYS * SETS + int'(way) * SETS + int'(set);
            m_vld[wn] = w0[31]; m_epn[wn] = epn; m_tag[wn] = {w0[30:7], w0[5:0]};
            m_hs[wn] = w0[6]; m_w1[wn] = w1;
        end
    endtask

    task automatic lookup(input string req, input logic [31:0] ea, input logic [29:0] tag,
                          input logic key, input logic nx, input logic [1:0] acc);
        op(req, 1, 1, ea, tag, key, nx, acc, 0, 0, 0, '0, '0, '0, '0);
    endtask

    task automatic load_entry(input logic side, input logic way, input logic [4:0] set,
                              input logic [19:0] epn, input logic [31:0] w0,
                              input logic [31:0] w1);
        op("", 0, 0, '0, '0, 0, 0, 2'd0, 1, side, way, set, epn, w0, w1);
    endtask

    // Monitor: compares mid-cycle, after the driver has settled the inputs
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #2;
            if (scb_q.size() != 0) begin
                e = scb_q.pop_front();
                checks++;
                if (lk_code !== e.code || lk_hit !== (e.code == 2'd0 || e.code == 2'd2) ||
                    lk_rpn !== e.rpn || lk_wimg !== e.wimg || lk_prot !== e.prot ||
                    lk_rc !== e.rc) begin
                    errors++;
                    $display("FAIL %s: got code=%0d hit=%0b rpn=%h wimg=%h prot=%b rc=%b exp code=%0d rpn=%h wimg=%h prot=%b rc=%b",
                             e.req, lk_code, lk_hit, lk_rpn, lk_wimg, lk_prot, lk_rc,
                             e.code, e.rpn, e.wimg, e.prot, e.rc);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        if (!ended) begin
            ended = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    localparam logic [29:0] TA = 30'h0123_4567;
    localparam logic [29:0] TB = 30'h2AAA_5555;

    initial begin
        for (int i = 0; i < TOTAL; i++) begin
            m_vld[i] = 0; m_epn[i] = '0; m_tag[i] = '0; m_hs[i] = 0; m_w1[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state and idle outputs
        op("R1 idle", 1, 0, '0, '0, 0, 0, 2'd0, 0, 0, 0, '0, '0, '0, '0);
        lookup("R1 empty after reset", 32'h0000_1000, TA, 0, 0, 2'd0);

        // R5 R9: load grants, write stripped while changed is clear
        load_entry(0, 0, 5'd1, 20'h00001, mk_w0(TA, 0), mk_w1(20'hABCDE, 0, 0, 4'h5, 2'd2));
        lookup("R5 R9 load grant", 32'h0000_1234, TA, 0, 0, 2'd0);
        lookup("R8 referenced visible", 32'h0000_1234, TA, 0, 0, 2'd0);
        lookup("R9 store grant sets changed", 32'h0000_1234, TA, 0, 0, 2'd1);
        lookup("R9 changed visible", 32'h0000_1234, TA, 0, 0, 2'd0);

        // R2: fetch uses the instruction half only
        lookup("R2 fetch misses data half", 32'h0000_1234, TA, 0, 0, 2'd2);
        load_entry(1, 1, 5'd1, 20'h00001, mk_w0(TA, 0), mk_w1(20'h11111, 0, 0, 4'h0, 2'd2));
        lookup("R4 R6 no-execute deny", 32'h0000_1000, TA, 0, 1, 2'd2);
        lookup("R5 fetch grant", 32'h0000_1000, TA, 0, 0, 2'd2);

        // R2: higher page number landing in the same set
        load_entry(0, 1, 5'd1, 20'h00021, mk_w0(TA, 0), mk_w1(20'h22222, 0, 0, 4'hA, 2'd0));
        lookup("R2 same set other way", 32'h0002_1000, TA, 0, 0, 2'd0);

        // R4 R6 R8: key 1 protection table
        load_entry(0, 0, 5'd2, 20'h00002, mk_w0(TB, 0), mk_w1(20'h33333, 0, 0, 4'h0, 2'd0));
        lookup("R4 R6 key1 pp0 deny", 32'h0000_2000, TB, 1, 0, 2'd0);
        lookup("R8 deny sets referenced", 32'h0000_2000, TB, 1, 0, 2'd0);
        load_entry(0, 0, 5'd2, 20'h00002, mk_w0(TB, 0), mk_w1(20'h33333, 0, 1, 4'h0, 2'd1));
        lookup("R4 key1 pp1 store deny", 32'h0000_2000, TB, 1, 0, 2'd1);
        load_entry(0, 0, 5'd2, 20'h00002, mk_w0(TB, 0), mk_w1(20'h33333, 0, 1, 4'h0, 2'd3));
        lookup("R4 key1 pp3 load", 32'h0000_2000, TB, 1, 0, 2'd0);
        lookup("R4 key0 pp3 store deny", 32'h0000_2000, TB, 0, 0, 2'd1);
        load_entry(0, 0, 5'd2, 20'h00002, mk_w0(TB, 0), mk_w1(20'h33333, 0, 1, 4'h0, 2'd2));
        lookup("R4 key1 pp2 store", 32'h0000_2000, TB, 1, 0, 2'd1);

        // R3: each match condition
        lookup("R3 tag differs", 32'h0000_2000, TA, 0, 0, 2'd0);
        lookup("R3 page differs", 32'h0004_2000, TB, 0, 0, 2'd0);
        load_entry(0, 1, 5'd6, 20'h00006, mk_w0(TA, 1), mk_w1(20'h44444, 0, 0, 4'h0, 2'd2));
        lookup("R3 hash-select set", 32'h0000_6000, TA, 0, 0, 2'd0);
        load_entry(0, 1, 5'd6, 20'h00006, {1'b0, mk_w0(TA, 0) & 32'h7FFF_FFFF}, mk_w1(20'h44444, 0, 0, 4'h0, 2'd2));
        lookup("R3 invalid entry", 32'h0000_6000, TA, 0, 0, 2'd0);

        // R7 R11: disagreeing pair
        load_entry(0, 0, 5'd3, 20'h00003, mk_w0(TA, 0), mk_w1(20'h55555, 0, 0, 4'h1, 2'd1));
        load_entry(0, 1, 5'd3, 20'h00003, mk_w0(TA, 0), mk_w1(20'h66666, 0, 0, 4'h1, 2'd1));
        lookup("R7 conflict after deny", 32'h0000_3000, TA, 1, 0, 2'd1);
        lookup("R7 R11 grant stops before conflict", 32'h0000_3000, TA, 1, 0, 2'd0);

        // R6: agreeing pair both deny, later way is selected
        load_entry(0, 0, 5'd4, 20'h00004, mk_w0(TB, 0), mk_w1(20'h77777, 0, 0, 4'h2, 2'd0));
        load_entry(0, 1, 5'd4, 20'h00004, mk_w0(TB, 0), mk_w1(20'h77777, 1, 1, 4'h2, 2'd0));
        lookup("R6 agreeing deny pair", 32'h0000_4000, TB, 1, 0, 2'd0);

        // R10: hit write-back and software write to the same entry
        op("R10 collision lookup", 1, 1, 32'h0000_1000, TA, 0, 0, 2'd0,
           1, 0, 0, 5'd1, 20'h00001, mk_w0(TA, 0), mk_w1(20'h99999, 0, 0, 4'h3, 2'd2));
        lookup("R10 software write wins", 32'h0000_1000, TA, 0, 0, 2'd0);

        op("R1 idle end", 1, 0, '0, '0, 0, 0, 2'd0, 0, 0, 0, '0, '0, '0, '0);
        repeat (3) @(negedge clk);
        if (!ended) begin
            ended = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule